// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the enable and address inputs of both ports. When both ports are enabled on the same address in the same cycle, it raises a busy flag on exactly one of them and blocks that port's writes, so the array never takes two writes to one word at once. The port whose enable and address settled in an earlier clock cycle wins. The other port is flagged busy. If both settle in the same cycle, a fixed rule chosen by parameter picks the loser.

All timing is synchronous to one clock. The inputs are sampled on a rising edge, and the registered busy and write-permit outputs show the decision from the next rising edge on. A decision holds for as long as the collision lasts. It is released one cycle after the addresses differ or an enable drops. In master configuration the block does the arbitration and drives both busy outputs. In slave configuration it does no arbitration: its busy inputs, driven by a master elsewhere, block writes on their port and are echoed on the busy outputs.

Top module: `dpCollisionArbiter`

## Requirements
- R1: When an enable is low or the two addresses differ in the sampled cycle, both busy outputs are 0 after the next rising edge, and each writeOk output equals that port's wr AND en.
- R2: When both ports are enabled on equal addresses and exactly one port's {en, addr} changed at the sampling edge, the port that changed (the later arrival) shows busy=1 and the other shows busy=0.
- R3: When both ports' {en, addr} change at the same edge into a collision, the right port loses if TIE_LEFT_WINS=1 and the left port loses if TIE_LEFT_WINS=0.
- R4: In master configuration busyL and busyR are never 1 together.
- R5: writeOk of a port is 1 only if that port has en=1, wr=1 and its own busy decision for that cycle is 0. The loser's write is therefore blocked in the same cycle its busy rises.
- R6: While a collision lasts with unchanged inputs, the busy decision keeps its value. It is released one cycle after the collision ends. A later collision is judged again by arrival order, so a winner that leaves and returns becomes the later arrival.
- R7: With MASTER=0 there is no arbitration. busyL and busyR equal busyInL and busyInR sampled at the previous edge, and an input value of 1 blocks writeOk on that port.
- R8: All outputs are registered and are 0 while rstN is low. After reset, the first enable seen on a port counts as a change of that port.
- R9: Addresses are ADDR_W bits wide (16 by default) and are compared over all bits, so addresses differing only in the top bit do not collide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| enL | input | 1 | Left port enable |
| addrL | input | ADDR_W | Left port address |
| wrL | input | 1 | Left port write request |
| enR | input | 1 | Right port enable |
| addrR | input | ADDR_W | Right port address |
| wrR | input | 1 | Right port write request |
| busyInL | input | 1 | Slave mode: external busy for left port (1 = busy) |
| busyInR | input | 1 | Slave mode: external busy for right port (1 = busy) |
| busyL | output | 1 | Left port busy (1 = busy) |
| busyR | output | 1 | Right port busy (1 = busy) |
| writeOkL | output | 1 | Left write permitted this cycle |
| writeOkR | output | 1 | Right write permitted this cycle |

## Verification
The hardest case to reach is a winner that leaves the collided address and then comes back while the loser stays parked on it. The decision must flip, because the returning port is now the later arrival. A stale held decision would keep the old loser. Directed sequences build this case in both directions and also make both ports change in the same cycle, so the tie rule is exercised. A long run of random traffic over a two-bit slice of addresses then produces frequent collisions, tie arrivals and busy-input toggles. Three instances share the same stimulus: a master with the left-wins tie rule, a master with the right-wins tie rule, and a slave.

// File: rtl/dpArbPkg.sv
package dpArbPkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L    = 0;
  localparam int unsigned PORT_R    = 1;

  // per-port view produced by the datapath
  typedef struct packed {
    logic moved;   // {en,addr} differs from the previous sample
    logic active;  // enable
    logic wrReq;   // write request
  } portView_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PORTS-1:0] busyNext;
    logic [NUM_PORTS-1:0] okNext;
  } arbStrobe_t;
endpackage

// File: rtl/dpArbDatapath.sv
module dpArbDatapath
  import dpArbPkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_PORTS-1:0]                enVec,
  input  logic [NUM_PORTS-1:0]                wrVec,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    addrVec,
  input  arbStrobe_t                          strobe,
  output portView_t [NUM_PORTS-1:0]           view,
  output logic                                match,
  output logic [NUM_PORTS-1:0]                busyQ,
  output logic [NUM_PORTS-1:0]                okQ
);
  logic [NUM_PORTS-1:0]             prevEn;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] prevAddr;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevEn[g]   <= 1'b0;
        prevAddr[g] <= '0;
        busyQ[g]    <= 1'b0;
        okQ[g]      <= 1'b0;
      end else begin
        prevEn[g]   <= enVec[g];
        prevAddr[g] <= addrVec[g];
        busyQ[g]    <= strobe.busyNext[g];
        okQ[g]      <= strobe.okNext[g];
      end
    end

    always_comb begin
      view[g].moved  = (enVec[g] != prevEn[g]) || (addrVec[g] != prevAddr[g]);
      view[g].active = enVec[g];
      view[g].wrReq  = wrVec[g];
    end
  end

  assign match = (&enVec) && (addrVec[PORT_L] == addrVec[PORT_R]);
endmodule

// File: rtl/dpArbControl.sv
module dpArbControl
  import dpArbPkg::*;
#(
  parameter bit MASTER        = 1'b1,
  parameter bit TIE_LEFT_WINS = 1'b1
) (
  input  portView_t [NUM_PORTS-1:0] view,
  input  logic                      match,
  input  logic [NUM_PORTS-1:0]      busyQ,
  input  logic [NUM_PORTS-1:0]      busyIn,
  output arbStrobe_t                strobe
);
  logic                 movedL, movedR, leftLoses;
  logic [NUM_PORTS-1:0] arbBusy, block;

  assign movedL = view[PORT_L].moved;
  assign movedR = view[PORT_R].moved;

  // later arrival loses; same-cycle arrival uses the tie rule; no change holds
  always_comb begin
    if (movedL && !movedR)      leftLoses = 1'b1;
    else if (movedR && !movedL) leftLoses = 1'b0;
    else if (movedL && movedR)  leftLoses = !TIE_LEFT_WINS;
    else                        leftLoses = busyQ[PORT_L];
  end

  always_comb begin
    arbBusy         = '0;
    arbBusy[PORT_L] = match && leftLoses;
    arbBusy[PORT_R] = match && !leftLoses;
    block           = MASTER ? arbBusy : busyIn;
    strobe.busyNext = block;
    for (int p = 0; p < NUM_PORTS; p++) begin
      strobe.okNext[p] = view[p].active && view[p].wrReq && !block[p];
    end
  end
endmodule

// File: rtl/dpCollisionArbiter.sv
module dpCollisionArbiter
  import dpArbPkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter bit          MASTER        = 1'b1,
  parameter bit          TIE_LEFT_WINS = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              wrL,
  input  logic              enR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              wrR,
  input  logic              busyInL,
  input  logic              busyInR,
  output logic              busyL,
  output logic              busyR,
  output logic              writeOkL,
  output logic              writeOkR
);
  logic [NUM_PORTS-1:0]             enVec, wrVec, busyInVec, busyQ, okQ;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrVec;
  portView_t [NUM_PORTS-1:0]        view;
  logic                             match;
  arbStrobe_t                       strobe;

  assign enVec     = {enR, enL};
  assign wrVec     = {wrR, wrL};
  assign busyInVec = {busyInR, busyInL};
  assign addrVec   = {addrR, addrL};

  dpArbDatapath #(.ADDR_W(ADDR_W)) uDatapath (
    .clk(clk), .rstN(rstN), .enVec(enVec), .wrVec(wrVec), .addrVec(addrVec),
    .strobe(strobe), .view(view), .match(match), .busyQ(busyQ), .okQ(okQ)
  );

  dpArbControl #(.MASTER(MASTER), .TIE_LEFT_WINS(TIE_LEFT_WINS)) uControl (
    .view(view), .match(match), .busyQ(busyQ), .busyIn(busyInVec), .strobe(strobe)
  );

  assign busyL    = busyQ[PORT_L];
  assign busyR    = busyQ[PORT_R];
  assign writeOkL = okQ[PORT_L];
  assign writeOkR = okQ[PORT_R];
endmodule

// File: rtl/dpArbChecker.sv
module dpArbChecker #(
  parameter int unsigned ADDR_W = 16,
  parameter bit          MASTER = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              enL,
  input logic [ADDR_W-1:0] addrL,
  input logic              wrL,
  input logic              enR,
  input logic [ADDR_W-1:0] addrR,
  input logic              wrR,
  input logic              busyInL,
  input logic              busyInR,
  input logic              busyL,
  input logic              busyR,
  input logic              writeOkL,
  input logic              writeOkR
);
  logic [1:0]                 age;
  logic                       collide, sameIn;
  logic [2*ADDR_W+1:0]        prevIn;

  assign collide = enL && enR && (addrL == addrR);
  assign sameIn  = (prevIn == {enL, addrL, enR, addrR}) && (age != 2'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      age    <= 2'd0;
      prevIn <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      prevIn <= {enL, addrL, enR, addrR};
    end
  end

  p_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    (MASTER && age != 2'd0 && !$past(collide)) |-> (!busyL && !busyR));

  p_one_loser_r2: assert property (@(posedge clk) disable iff (!rstN)
    (MASTER && age != 2'd0 && $past(collide)) |-> (busyL != busyR));

  p_never_both_r4: assert property (@(posedge clk) disable iff (!rstN)
    MASTER |-> !(busyL && busyR));

  p_block_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyL |-> !writeOkL);

  p_block_right_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyR |-> !writeOkR);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (MASTER && age >= 2'd2 && $past(collide) && $past(sameIn)) |-> $stable(busyL));

  p_slave_echo_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!MASTER && age != 2'd0) |-> (busyL == $past(busyInL) && busyR == $past(busyInR)));

  p_write_needs_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    (age != 2'd0 && writeOkL) |-> $past(enL && wrL));
endmodule

bind dpCollisionArbiter dpArbChecker #(.ADDR_W(ADDR_W), .MASTER(MASTER)) uChecker (
  .clk(clk), .rstN(rstN), .enL(enL), .addrL(addrL), .wrL(wrL),
  .enR(enR), .addrR(addrR), .wrR(wrR), .busyInL(busyInL), .busyInR(busyInR),
  .busyL(busyL), .busyR(busyR), .writeOkL(writeOkL), .writeOkR(writeOkR)
);

// File: tb/test_dpCollisionArbiter.sv
`timescale 1ns/1ps
module test_dpCollisionArbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enL = 1'b0, enR = 1'b0, wrL = 1'b0, wrR = 1'b0;
  logic [15:0] addrL = '0, addrR = '0;
  logic        busyInL = 1'b0, busyInR = 1'b0;
  logic        mBusyL, mBusyR, mOkL, mOkR;
  logic        tBusyL, tBusyR, tOkL, tOkR;
  logic        sBusyL, sBusyR, sOkL, sOkR;

  int    compared = 0, mismatched = 0, cycles = 0;
  string phaseTag = "R8";

  always #2 clk = ~clk;

  dpCollisionArbiter #(.ADDR_W(16), .MASTER(1'b1), .TIE_LEFT_WINS(1'b1)) i_dpCollisionArbiter (
    .clk(clk), .rstN(rstN), .enL(enL), .addrL(addrL), .wrL(wrL), .enR(enR), .addrR(addrR),
    .wrR(wrR), .busyInL(busyInL), .busyInR(busyInR),
    .busyL(mBusyL), .busyR(mBusyR), .writeOkL(mOkL), .writeOkR(mOkR));

  dpCollisionArbiter #(.ADDR_W(16), .MASTER(1'b1), .TIE_LEFT_WINS(1'b0)) i_dpCollisionArbiterTieR (
    .clk(clk), .rstN(rstN), .enL(enL), .addrL(addrL), .wrL(wrL), .enR(enR), .addrR(addrR),
    .wrR(wrR), .busyInL(busyInL), .busyInR(busyInR),
    .busyL(tBusyL), .busyR(tBusyR), .writeOkL(tOkL), .writeOkR(tOkR));

  dpCollisionArbiter #(.ADDR_W(16), .MASTER(1'b0), .TIE_LEFT_WINS(1'b1)) i_dpCollisionArbiterSlave (
    .clk(clk), .rstN(rstN), .enL(enL), .addrL(addrL), .wrL(wrL), .enR(enR), .addrR(addrR),
    .wrR(wrR), .busyInL(busyInL), .busyInR(busyInR),
    .busyL(sBusyL), .busyR(sBusyR), .writeOkL(sOkL), .writeOkR(sOkR));

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // behavioural reference: index 0 = left-wins tie, 1 = right-wins tie
  bit        pEnL, pEnR;
  bit [15:0] pAddrL, pAddrR;
  bit        loseLeft [2];
  bit        eBusyL [2], eBusyR [2], eOkL [2], eOkR [2];
  bit        eSBusyL, eSBusyR, eSOkL, eSOkR;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      pEnL = 0; pEnR = 0; pAddrL = 0; pAddrR = 0;
      for (int k = 0; k < 2; k++) begin
        loseLeft[k] = 0; eBusyL[k] = 0; eBusyR[k] = 0; eOkL[k] = 0; eOkR[k] = 0;
      end
      eSBusyL = 0; eSBusyR = 0; eSOkL = 0; eSOkR = 0;
    end else begin
      bit chL, chR, hit;
      chL = (enL != pEnL) || (addrL != pAddrL);
      chR = (enR != pEnR) || (addrR != pAddrR);
      hit = enL && enR && (addrL == addrR);
      for (int k = 0; k < 2; k++) begin
        if (hit) begin
          if (chL && !chR)      loseLeft[k] = 1;
          else if (chR && !chL) loseLeft[k] = 0;
          else if (chL && chR)  loseLeft[k] = (k == 1);
        end
        eBusyL[k] = hit && loseLeft[k];
        eBusyR[k] = hit && !loseLeft[k];
        eOkL[k]   = enL && wrL && !eBusyL[k];
        eOkR[k]   = enR && wrR && !eBusyR[k];
      end
      eSBusyL = busyInL; eSBusyR = busyInR;
      eSOkL   = enL && wrL && !busyInL;
      eSOkR   = enR && wrR && !busyInR;
      pEnL = enL; pEnR = enR; pAddrL = addrL; pAddrR = addrR;
    end
    #1;
    chk(phaseTag, "master busyL", mBusyL, eBusyL[0]);
    chk(phaseTag, "master busyR", mBusyR, eBusyR[0]);
    chk({phaseTag, "/R5"}, "master writeOkL", mOkL, eOkL[0]);
    chk({phaseTag, "/R5"}, "master writeOkR", mOkR, eOkR[0]);
    chk({phaseTag, "/R3"}, "tieR busyL", tBusyL, eBusyL[1]);
    chk({phaseTag, "/R3"}, "tieR busyR", tBusyR, eBusyR[1]);
    chk({phaseTag, "/R5"}, "tieR writeOkL", tOkL, eOkL[1]);
    chk({phaseTag, "/R5"}, "tieR writeOkR", tOkR, eOkR[1]);
    chk("R7", "slave busyL", sBusyL, eSBusyL);
    chk("R7", "slave busyR", sBusyR, eSBusyR);
    chk("R7", "slave writeOkL", sOkL, eSOkL);
    chk("R7", "slave writeOkR", sOkR, eSOkR);
    chk("R4", "master both busy", mBusyL && mBusyR, 1'b0);
    chk("R4", "tieR both busy", tBusyL && tBusyR, 1'b0);
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: run exceeded cycle limit actual=%0d expected<=20000", cycles);
      finishRun();
    end
  end

  task automatic drive(input bit eL, input bit [15:0] aL, input bit wL,
                       input bit eR, input bit [15:0] aR, input bit wR, input int hold);
    @(negedge clk);
    enL = eL; addrL = aL; wrL = wL; enR = eR; addrR = aR; wrR = wR;
    for (int i = 1; i < hold; i++) @(negedge clk);
  endtask

  initial begin
    // R8: reset with busy-looking inputs applied
    phaseTag = "R8";
    drive(1, 16'h0010, 1, 1, 16'h0010, 1, 3);
    @(negedge clk); rstN = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 2);

    // R1: no collision
    phaseTag = "R1";
    drive(1, 16'h0100, 1, 1, 16'h0101, 1, 3);
    drive(1, 16'h0200, 1, 0, 16'h0200, 1, 2);
    drive(0, 16'h0300, 1, 1, 16'h0300, 1, 2);

    // R9: differ only in the top address bit
    phaseTag = "R9";
    drive(1, 16'hFFFF, 1, 1, 16'h7FFF, 1, 3);
    drive(1, 16'h0000, 1, 1, 16'h8000, 1, 2);

    // R2: left arrives first, right collides later, then the reverse
    phaseTag = "R2";
    drive(1, 16'h1234, 1, 0, 16'h0000, 1, 2);
    drive(1, 16'h1234, 1, 1, 16'h1234, 1, 4);
    drive(0, 0, 0, 0, 0, 0, 2);
    drive(0, 16'h0000, 1, 1, 16'hFFFF, 1, 2);
    drive(1, 16'hFFFF, 1, 1, 16'hFFFF, 1, 4);

    // R6: loser leaves and returns (stays loser); winner leaves and returns (now loser)
    phaseTag = "R6";
    drive(0, 16'hFFFF, 1, 1, 16'hFFFF, 1, 2);
    drive(1, 16'hFFFF, 1, 1, 16'hFFFF, 1, 3);
    drive(1, 16'hFFFF, 1, 1, 16'h0001, 1, 2);
    drive(1, 16'hFFFF, 1, 1, 16'hFFFF, 0, 3);
    drive(1, 16'h4000, 0, 1, 16'hFFFF, 1, 1);
    drive(1, 16'hFFFF, 1, 1, 16'hFFFF, 1, 3);

    // R3: both arrive in one cycle, including a jump of both to a new shared address
    phaseTag = "R3";
    drive(0, 0, 0, 0, 0, 0, 2);
    drive(1, 16'h0055, 1, 1, 16'h0055, 1, 3);
    drive(1, 16'h0066, 1, 1, 16'h0066, 1, 3);
    drive(0, 0, 0, 0, 0, 0, 2);

    // R7: slave busy inputs with writes on both ports
    phaseTag = "R7";
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      enL = 1; enR = 1; wrL = 1; wrR = 1; addrL = 16'(i); addrR = 16'(i + 1);
      busyInL = i[0]; busyInR = i[1];
    end

    // random traffic over a small address slice
    phaseTag = "R2";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      enL = ($urandom % 4) != 0; enR = ($urandom % 4) != 0;
      wrL = ($urandom % 2) != 0; wrR = ($urandom % 2) != 0;
      if (($urandom % 3) == 0) addrL = 16'($urandom % 3);
      if (($urandom % 3) == 0) addrR = 16'($urandom % 3);
      busyInL = ($urandom % 2) != 0; busyInR = ($urandom % 2) != 0;
    end

    drive(0, 0, 0, 0, 0, 0, 3);
    finishRun();
  end
endmodule